// File: doc/BRIEF.md
# Battery Pack Protection Supervisor

This block is the digital decision core of a protection circuit for a series lithium-ion pack of three or four cells. Analog comparators outside the block compare each cell against an upper limit, a lower limit and a minimum charge level. They also compare the sense-resistor voltage against an over-current limit. Each comparator delivers a one-bit flag. The block qualifies every fault condition with its own programmable delay counter. From the qualified faults it drives the enable of the charge FET, the enable of the discharge FET and the enable of a test current used to probe the load.

An over-voltage fault turns only the charge path off. An under-voltage or over-current fault turns only the discharge path off. The over-voltage and under-voltage faults release by themselves once every monitored cell is back inside its limit. The over-current fault does not time out. It holds the discharge path off and sources the load test current until an external comparator reports that the load resistance has risen above its release limit. A configuration input drops the top cell from monitoring for three-cell packs. A second configuration input lets charging proceed even when some cell is below its minimum charge level. A three-bit status word summarises the state for a host.

Top module: `pack_guard`

## Requirements
- R1: During reset both FET enables, the test-current enable and all status bits are 0. After reset both FET enables stay 0 until reg_good has been sampled 1. They rise on that same clock edge and remain armed even if reg_good later falls.
- R2: If any monitored cell's over-voltage flag is 1 for D+1 consecutive clock edges, where D is cfg_ov_dly, then chg_fet_on goes to 0 on the last of those edges. dis_fet_on is not affected.
- R3: A qualifying condition that drops before its delay expires restarts its counter from zero. A later run must again last D+1 edges to trip.
- R4: The over-voltage fault clears, and chg_fet_on returns to 1, on the first edge at which no monitored cell reports over-voltage.
- R5: If any monitored cell's under-voltage flag is 1 for cfg_uv_dly+1 consecutive edges, then dis_fet_on goes to 0. It returns to 1 on the first edge at which no monitored cell reports under-voltage.
- R6: If oc_flag is 1 for cfg_oc_dly+1 consecutive edges, then dis_fet_on goes to 0 and lmon_en goes to 1. Both hold regardless of oc_flag until load_rel is sampled 1. On that edge lmon_en returns to 0 and dis_fet_on is released.
- R7: When cfg_four_cell is 0, all three flags of cell index 3 (the top cell) are ignored.
- R8: When cfg_low_chg_ok is 0 and any monitored cell's below-charge flag is 1, chg_fet_on is 0 from the next edge onward. When cfg_low_chg_ok is 1, below-charge flags have no effect.
- R9: status[0] is the registered reg_good OR the over-current fault. status[1] is the under-voltage fault. status[2] is the charge inhibit OR the over-voltage fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_four_cell | input | 1 | 1: monitor all cells; 0: ignore cell index 3 |
| cfg_low_chg_ok | input | 1 | 1: below-charge flags do not block charging |
| cfg_ov_dly | input | DLY_W | Over-voltage qualify delay in cycles |
| cfg_uv_dly | input | DLY_W | Under-voltage qualify delay in cycles |
| cfg_oc_dly | input | DLY_W | Over-current qualify delay in cycles |
| cell_ov | input | N_CELLS | Per-cell above-upper-limit flags |
| cell_uv | input | N_CELLS | Per-cell below-lower-limit flags |
| cell_low | input | N_CELLS | Per-cell below-charge-level flags |
| oc_flag | input | 1 | Sense voltage above over-current limit |
| load_rel | input | 1 | Load resistance above release limit |
| reg_good | input | 1 | Regulator output stable |
| chg_fet_on | output | 1 | Charge FET enable |
| dis_fet_on | output | 1 | Discharge FET enable |
| lmon_en | output | 1 | Load test-current enable |
| status | output | 3 | Status word as in R9 |

## Verification
The assertions assume that load_rel is only meaningful while the over-current fault is held. They also assume that the configuration inputs stay steady while a fault is being qualified. The stimulus therefore changes cfg_four_cell, cfg_low_chg_ok and the delays only between scenarios, never during a counting run. It raises load_rel only after the over-current fault has latched, and lowers oc_flag before it raises load_rel, so that a release is never followed at once by a fresh trip from a still-high flag.

// File: rtl/pack_guard_pkg.sv
package pack_guard_pkg;
    localparam int FLT_N  = 3;
    localparam int IDX_OV = 0;
    localparam int IDX_UV = 1;
    localparam int IDX_OC = 2;

    typedef struct packed {
        logic armed;
        logic rg;
        logic ov;
        logic uv;
        logic oc;
        logic inh;
        logic chg;
        logic dis;
    } guard_st_t;
endpackage

// File: rtl/flag_filter.sv
module flag_filter #(
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             cond_i,
    input  logic [DLY_W-1:0] dly_i,
    output logic             trip_o
);
    logic [DLY_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!en_i || !cond_i) begin
            cnt_d = '0;
        end else if (cnt_q != dly_i) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // condition held for dly_i+1 consecutive samples
    assign trip_o = en_i && cond_i && (cnt_q == dly_i);
endmodule

// File: rtl/cell_screen.sv
module cell_screen #(
    parameter int N_CELLS = 4
) (
    input  logic               four_cell_i,
    input  logic [N_CELLS-1:0] ov_i,
    input  logic [N_CELLS-1:0] uv_i,
    input  logic [N_CELLS-1:0] low_i,
    output logic               any_ov_o,
    output logic               any_uv_o,
    output logic               any_low_o
);
    logic [N_CELLS-1:0] mask;

    genvar gi;
    generate
        for (gi = 0; gi < N_CELLS; gi++) begin : g_mask
            if (gi == N_CELLS-1) begin : g_top
                assign mask[gi] = four_cell_i;
            end else begin : g_low
                assign mask[gi] = 1'b1;
            end
        end
    endgenerate

    assign any_ov_o  = |(ov_i  & mask);
    assign any_uv_o  = |(uv_i  & mask);
    assign any_low_o = |(low_i & mask);
endmodule

// File: rtl/pack_guard.sv
module pack_guard
    import pack_guard_pkg::*;
#(
    parameter int N_CELLS = 4,
    parameter int DLY_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_four_cell,
    input  logic               cfg_low_chg_ok,
    input  logic [DLY_W-1:0]   cfg_ov_dly,
    input  logic [DLY_W-1:0]   cfg_uv_dly,
    input  logic [DLY_W-1:0]   cfg_oc_dly,
    input  logic [N_CELLS-1:0] cell_ov,
    input  logic [N_CELLS-1:0] cell_uv,
    input  logic [N_CELLS-1:0] cell_low,
    input  logic               oc_flag,
    input  logic               load_rel,
    input  logic               reg_good,
    output logic               chg_fet_on,
    output logic               dis_fet_on,
    output logic               lmon_en,
    output logic [2:0]         status
);
    guard_st_t st_d, st_q;

    logic any_ov, any_uv, any_low;
    logic [FLT_N-1:0]       cond;
    logic [FLT_N-1:0]       flt_en;
    logic [FLT_N-1:0]       trip;
    logic [DLY_W-1:0]       dly [FLT_N];

    // visible fault state for the bound checker
    logic ov_flt, uv_flt, oc_flt, armed;

    cell_screen #(.N_CELLS(N_CELLS)) u_screen (
        .four_cell_i (cfg_four_cell),
        .ov_i        (cell_ov),
        .uv_i        (cell_uv),
        .low_i       (cell_low),
        .any_ov_o    (any_ov),
        .any_uv_o    (any_uv),
        .any_low_o   (any_low)
    );

    assign cond[IDX_OV]   = any_ov;
    assign cond[IDX_UV]   = any_uv;
    assign cond[IDX_OC]   = oc_flag;
    assign flt_en[IDX_OV] = !st_q.ov;
    assign flt_en[IDX_UV] = !st_q.uv;
    assign flt_en[IDX_OC] = !st_q.oc;
    assign dly[IDX_OV]    = cfg_ov_dly;
    assign dly[IDX_UV]    = cfg_uv_dly;
    assign dly[IDX_OC]    = cfg_oc_dly;

    genvar fi;
    generate
        for (fi = 0; fi < FLT_N; fi++) begin : g_filt
            flag_filter #(.DLY_W(DLY_W)) u_filt (
                .clk    (clk),
                .rst_n  (rst_n),
                .en_i   (flt_en[fi]),
                .cond_i (cond[fi]),
                .dly_i  (dly[fi]),
                .trip_o (trip[fi])
            );
        end
    endgenerate

    always_comb begin
        st_d       = st_q;
        st_d.armed = st_q.armed | reg_good;
        st_d.rg    = reg_good;
        st_d.inh   = !cfg_low_chg_ok && any_low;

        if (trip[IDX_OV])   st_d.ov = 1'b1;
        else if (!any_ov)   st_d.ov = 1'b0;

        if (trip[IDX_UV])   st_d.uv = 1'b1;
        else if (!any_uv)   st_d.uv = 1'b0;

        if (st_q.oc && load_rel) st_d.oc = 1'b0;
        else if (trip[IDX_OC])   st_d.oc = 1'b1;

        st_d.chg = st_d.armed && !st_d.ov && !st_d.inh;
        st_d.dis = st_d.armed && !st_d.uv && !st_d.oc;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign chg_fet_on = st_q.chg;
    assign dis_fet_on = st_q.dis;
    assign lmon_en    = st_q.oc;
    assign status     = {st_q.inh | st_q.ov, st_q.uv, st_q.rg | st_q.oc};

    assign ov_flt = st_q.ov;
    assign uv_flt = st_q.uv;
    assign oc_flt = st_q.oc;
    assign armed  = st_q.armed;
endmodule

// File: rtl/pack_guard_chk.sv
module pack_guard_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       chg_fet_on,
    input logic       dis_fet_on,
    input logic       lmon_en,
    input logic [2:0] status,
    input logic       load_rel,
    input logic       ov_flt,
    input logic       uv_flt,
    input logic       oc_flt,
    input logic       armed
);
    // R1
    fet_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chg_fet_on || dis_fet_on) |-> armed);

    // R1
    armed_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed |=> armed);

    // R2
    ov_blocks_chg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ov_flt |-> !chg_fet_on);

    // R5
    uv_blocks_dis_chk: assert property (@(posedge clk) disable iff (!rst_n)
        uv_flt |-> !dis_fet_on);

    // R6
    oc_blocks_dis_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oc_flt |-> !dis_fet_on);

    // R6
    oc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (oc_flt && !load_rel) |=> oc_flt);

    // R9
    lmon_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lmon_en |-> status[0]);
endmodule

bind pack_guard pack_guard_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .chg_fet_on (chg_fet_on),
    .dis_fet_on (dis_fet_on),
    .lmon_en    (lmon_en),
    .status     (status),
    .load_rel   (load_rel),
    .ov_flt     (ov_flt),
    .uv_flt     (uv_flt),
    .oc_flt     (oc_flt),
    .armed      (armed)
);

// File: tb/sim_pack_guard.sv
`timescale 1ns/1ps
module sim_pack_guard;
    localparam int NC = 4;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_four_cell = 1'b1;
    logic          cfg_low_chg_ok = 1'b1;
    logic [DW-1:0] cfg_ov_dly = 8'd3;
    logic [DW-1:0] cfg_uv_dly = 8'd3;
    logic [DW-1:0] cfg_oc_dly = 8'd3;
    logic [NC-1:0] cell_ov = '0, cell_uv = '0, cell_low = '0;
    logic          oc_flag = 1'b0, load_rel = 1'b0, reg_good = 1'b0;
    logic          chg_fet_on, dis_fet_on, lmon_en;
    logic [2:0]    status;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pack_guard #(.N_CELLS(NC), .DLY_W(DW)) u0 (
        .clk(clk), .rst_n(rst_n),
        .cfg_four_cell(cfg_four_cell), .cfg_low_chg_ok(cfg_low_chg_ok),
        .cfg_ov_dly(cfg_ov_dly), .cfg_uv_dly(cfg_uv_dly), .cfg_oc_dly(cfg_oc_dly),
        .cell_ov(cell_ov), .cell_uv(cell_uv), .cell_low(cell_low),
        .oc_flag(oc_flag), .load_rel(load_rel), .reg_good(reg_good),
        .chg_fet_on(chg_fet_on), .dis_fet_on(dis_fet_on),
        .lmon_en(lmon_en), .status(status)
    );

    typedef struct packed {
        logic [3:0] ov;
        logic [3:0] uv;
        logic [3:0] low;
        logic       oc;
        logic       rel;
        logic       rg;
        logic [3:0] edges;
        logic       chg;
        logic       dis;
        logic       lmon;
        logic [2:0] st;
    } vec_t;

    // delays all 3: a fault trips on the 4th consecutive edge
    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{4'h0, 4'h0, 4'h0, 1'b0, 1'b0, 1'b1, 4'd1, 1'b1, 1'b1, 1'b0, 3'b001}, // R1 armed
        '{4'h1, 4'h0, 4'h0, 1'b0, 1'b0, 1'b1, 4'd3, 1'b1, 1'b1, 1'b0, 3'b001}, // R2 not yet
        '{4'h1, 4'h0, 4'h0, 1'b0, 1'b0, 1'b1, 4'd1, 1'b0, 1'b1, 1'b0, 3'b101}, // R2 trip
        '{4'h0, 4'h0, 4'h0, 1'b0, 1'b0, 1'b1, 4'd1, 1'b1, 1'b1, 1'b0, 3'b001}, // R4 clear
        '{4'h4, 4'h0, 4'h0, 1'b0, 1'b0, 1'b1, 4'd2, 1'b1, 1'b1, 1'b0, 3'b001}, // R3 short run
        '{4'h0, 4'h0, 4'h0, 1'b0, 1'b0, 1'b1, 4'd1, 1'b1, 1'b1, 1'b0, 3'b001}, // R3 gap
        '{4'h4, 4'h0, 4'h0, 1'b0, 1'b0, 1'b1, 4'd3, 1'b1, 1'b1, 1'b0, 3'b001}, // R3 restarted
        '{4'h0, 4'h0, 4'h0, 1'b0, 1'b0, 1'b1, 4'd1, 1'b1, 1'b1, 1'b0, 3'b001}, // R3 idle
        '{4'h0, 4'h2, 4'h0, 1'b0, 1'b0, 1'b1, 4'd4, 1'b1, 1'b0, 1'b0, 3'b011}, // R5 trip
        '{4'h0, 4'h0, 4'h0, 1'b0, 1'b0, 1'b1, 4'd1, 1'b1, 1'b1, 1'b0, 3'b001}, // R5 clear
        '{4'h0, 4'h0, 4'h0, 1'b1, 1'b0, 1'b1, 4'd4, 1'b1, 1'b0, 1'b1, 3'b001}, // R6 trip
        '{4'h0, 4'h0, 4'h0, 1'b0, 1'b0, 1'b1, 4'd5, 1'b1, 1'b0, 1'b1, 3'b001}, // R6 hold
        '{4'h0, 4'h0, 4'h0, 1'b0, 1'b1, 1'b1, 4'd1, 1'b1, 1'b1, 1'b0, 3'b001}, // R6 release
        '{4'h0, 4'h0, 4'h9, 1'b0, 1'b0, 1'b1, 4'd2, 1'b1, 1'b1, 1'b0, 3'b001}  // R8 allowed
    };

    task automatic check(input string req, input logic c, input logic d,
                         input logic l, input logic [2:0] s);
        n_chk++;
        if (chg_fet_on !== c || dis_fet_on !== d || lmon_en !== l || status !== s) begin
            n_fail++;
            $display("FAIL %s actual chg=%b dis=%b lmon=%b st=%b expected chg=%b dis=%b lmon=%b st=%b",
                     req, chg_fet_on, dis_fet_on, lmon_en, status, c, d, l, s);
        end
    endtask

    task automatic edges(input int n);
        for (int k = 0; k < n; k++) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 20);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=expired expected=finished");
        finish_run();
    end

    initial begin
        // R1: reset state
        edges(2);
        check("R1 in reset", 1'b0, 1'b0, 1'b0, 3'b000);
        rst_n = 1'b1;
        edges(3);
        check("R1 no reg_good", 1'b0, 1'b0, 1'b0, 3'b000);

        for (int i = 0; i < NV; i++) begin
            cell_ov  = VECS[i].ov;
            cell_uv  = VECS[i].uv;
            cell_low = VECS[i].low;
            oc_flag  = VECS[i].oc;
            load_rel = VECS[i].rel;
            reg_good = VECS[i].rg;
            edges(int'(VECS[i].edges));
            check($sformatf("vector %0d", i), VECS[i].chg, VECS[i].dis,
                  VECS[i].lmon, VECS[i].st);
        end

        // R8: inhibit when allowance is off
        cell_low = 4'h1;
        cfg_low_chg_ok = 1'b0;
        edges(1);
        check("R8 inhibit", 1'b0, 1'b1, 1'b0, 3'b101);
        cell_low = 4'h0;
        edges(1);
        check("R8 released", 1'b1, 1'b1, 1'b0, 3'b001);

        // R7: three-cell mode ignores the top cell's flags
        cfg_four_cell = 1'b0;
        edges(1);
        cell_ov  = 4'h8;
        cell_uv  = 4'h8;
        cell_low = 4'h8;
        edges(6);
        check("R7 top cell masked", 1'b1, 1'b1, 1'b0, 3'b001);
        cfg_four_cell = 1'b1;
        edges(4);
        check("R7 top cell active", 1'b0, 1'b0, 1'b0, 3'b111);
        cell_ov  = 4'h0;
        cell_uv  = 4'h0;
        cell_low = 4'h0;
        cfg_low_chg_ok = 1'b1;
        edges(1);
        check("R4 R5 both clear", 1'b1, 1'b1, 1'b0, 3'b001);

        // R1: armed persists, status bit 0 follows reg_good
        reg_good = 1'b0;
        edges(1);
        check("R1 R9 reg_good low", 1'b1, 1'b1, 1'b0, 3'b000);

        // R2 with zero delay trips on first edge
        cfg_ov_dly = 8'd0;
        cell_ov = 4'h2;
        edges(1);
        check("R2 zero delay", 1'b0, 1'b1, 1'b0, 3'b100);
        cell_ov = 4'h0;
        edges(1);

        // R1: reset again, then reg_good arrives
        rst_n = 1'b0;
        edges(1);
        check("R1 reset again", 1'b0, 1'b0, 1'b0, 3'b000);
        rst_n = 1'b1;
        reg_good = 1'b1;
        edges(1);
        check("R1 arm on reg_good", 1'b1, 1'b1, 1'b0, 3'b001);

        finish_run();
    end
endmodule